// File: doc/BRIEF.md
# DMA versus CPU Memory Arbiter

This block decides, once per clock, which requester owns a shared memory port: the processor or one of several DMA channels. Each DMA channel comes with a two-bit urgency level. The level sets how the channel competes with the processor. Urgent channels always take the port. Background channels always give way to the processor. Regular channels share the port with the processor, turn and turn about.

Among DMA channels, a higher level always beats a lower one. Channels that tie on level are served in rotating order, so none of them is starved. A single pointer remembers where the next search begins.

The decision is registered. Requests presented before a clock edge produce a one-hot grant, or an all-zero grant, that is visible after that edge. Address and data steering, the memory and the transfer sequencing belong to the surrounding logic.

Top module: `dma_cpu_arbiter`

## Requirements
- R1: Reset clears every grant output, places the rotation pointer at channel 0 and clears the alternation bit. As a result, the first regular-level contest after reset goes to the processor.
- R2: At most one of `cpu_gnt_o` and the bits of `dma_gnt_o` is high in any cycle.
- R3: When no request is present before an edge, all grant outputs are zero after that edge.
- R4: A lone active requester is granted after the edge at which its request is sampled.
- R5: Each channel's level field is `dma_pri_i[2c+1:2c]`. It is decoded as follows: 2'b00 is background, 2'b01 is regular, 2'b10 is urgent and 2'b11 is also urgent.
- R6: If the highest requesting DMA level is urgent, the DMA side wins over a simultaneous processor request.
- R7: If all requesting DMA channels are background, a simultaneous processor request wins.
- R8: When the highest requesting DMA level is regular and the processor also requests, the winner alternates on successive such contests. Other cycles leave the alternation unchanged.
- R9: A DMA channel at a higher level is granted before any requesting channel at a lower level.
- R10: Among requesting channels of the winning level, the grant goes to the first one found at or after the rotation pointer, wrapping from N-1 to 0. After a DMA grant the pointer moves to the granted channel plus one, and it does not move otherwise.
- R11: A grant bit is high only if the matching request was high at the edge that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req_i | input | 1 | Processor memory request |
| dma_req_i | input | NUM_CH | Per-channel DMA request |
| dma_pri_i | input | 2*NUM_CH | Per-channel level field, two bits per channel |
| cpu_gnt_o | output | 1 | Registered grant to the processor |
| dma_gnt_o | output | NUM_CH | Registered one-hot grant to a DMA channel |

## Verification
The bench builds the arbiter with the default of five channels. The rotation pointer is then three bits wide with three unused codes, so the wrap from channel 4 back to channel 0 gets exercised, along with searches that start at every position. Five channels are enough to hold ties at every level together with a mix of levels in the same cycle. The random phase therefore reaches long runs of regular-level contests, where the alternation bit must survive intervening urgent and background cycles.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    LVL_BACK = 2'b00,
    LVL_REG  = 2'b01,
    LVL_URG  = 2'b10
  } lvl_e;

  // Both upper codes count as urgent.
  function automatic lvl_e field_to_lvl(input logic [1:0] fld);
    if (fld[1])            return LVL_URG;
    else if (fld == 2'b01) return LVL_REG;
    else                   return LVL_BACK;
  endfunction

endpackage

// File: rtl/arb_level_sort.sv
module arb_level_sort
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 5
) (
  input  logic [NUM_CH-1:0]   req_i,
  input  logic [2*NUM_CH-1:0] pri_i,
  output logic [NUM_CH-1:0]   urg_mask_o,
  output logic [NUM_CH-1:0]   reg_mask_o,
  output logic [NUM_CH-1:0]   back_mask_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    lvl_e lvl;
    assign lvl            = field_to_lvl(pri_i[2*c +: 2]);
    assign urg_mask_o[c]  = req_i[c] && (lvl == LVL_URG);
    assign reg_mask_o[c]  = req_i[c] && (lvl == LVL_REG);
    assign back_mask_o[c] = req_i[c] && (lvl == LVL_BACK);
  end

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NUM_CH = 5,
  parameter int PTR_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] cand_i,
  input  logic [PTR_W-1:0]  start_i,
  output logic              hit_o,
  output logic [PTR_W-1:0]  idx_o
);

  localparam logic [PTR_W:0] LIMIT = (PTR_W+1)'(NUM_CH);

  logic [PTR_W:0] pos;

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    pos   = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      pos = {1'b0, start_i} + (PTR_W+1)'(k);
      if (pos >= LIMIT) pos = pos - LIMIT;
      if (!hit_o && cand_i[pos[PTR_W-1:0]]) begin
        hit_o = 1'b1;
        idx_o = pos[PTR_W-1:0];
      end
    end
  end

endmodule

// File: rtl/arb_bus_policy.sv
module arb_bus_policy
  import dma_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n,
  input  logic cpu_req_i,
  input  logic dma_any_i,
  input  lvl_e top_lvl_i,
  output logic cpu_win_o,
  output logic dma_win_o
);

  logic alt_q, alt_d, alt_en;
  logic contest_reg;

  assign contest_reg = cpu_req_i && dma_any_i && (top_lvl_i == LVL_REG);

  always_comb begin
    cpu_win_o = 1'b0;
    dma_win_o = 1'b0;
    if (!dma_any_i) begin
      cpu_win_o = cpu_req_i;
    end else if (!cpu_req_i) begin
      dma_win_o = 1'b1;
    end else begin
      unique case (top_lvl_i)
        LVL_URG:  dma_win_o = 1'b1;
        LVL_REG:  begin
          dma_win_o = alt_q;
          cpu_win_o = !alt_q;
        end
        default:  cpu_win_o = 1'b1;
      endcase
    end
  end

  assign alt_en = contest_reg;
  assign alt_d  = !alt_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      alt_q <= 1'b0;
    else if (alt_en) alt_q <= alt_d;
  end

  // Two back-to-back regular contests never go the same way.
  assert_reg_alternates_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    contest_reg |=> !(contest_reg && (dma_win_o == $past(dma_win_o))));

endmodule

// File: rtl/dma_cpu_arbiter.sv
module dma_cpu_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_req_i,
  input  logic [NUM_CH-1:0]   dma_req_i,
  input  logic [2*NUM_CH-1:0] dma_pri_i,
  output logic                cpu_gnt_o,
  output logic [NUM_CH-1:0]   dma_gnt_o
);

  localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_CH - 1);

  // Reset: asserted at once, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [NUM_CH-1:0] urg_mask, reg_mask, back_mask;

  arb_level_sort #(.NUM_CH(NUM_CH)) u_sort (
    .req_i      (dma_req_i),
    .pri_i      (dma_pri_i),
    .urg_mask_o (urg_mask),
    .reg_mask_o (reg_mask),
    .back_mask_o(back_mask)
  );

  logic [NUM_CH-1:0] cand;
  lvl_e              top_lvl;

  always_comb begin
    if (|urg_mask) begin
      cand    = urg_mask;
      top_lvl = LVL_URG;
    end else if (|reg_mask) begin
      cand    = reg_mask;
      top_lvl = LVL_REG;
    end else begin
      cand    = back_mask;
      top_lvl = LVL_BACK;
    end
  end

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;
  logic             pick_hit;
  logic [PTR_W-1:0] pick_idx;

  arb_rr_pick #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_pick (
    .cand_i (cand),
    .start_i(ptr_q),
    .hit_o  (pick_hit),
    .idx_o  (pick_idx)
  );

  logic cpu_win, dma_win;

  arb_bus_policy u_policy (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .cpu_req_i(cpu_req_i),
    .dma_any_i(pick_hit),
    .top_lvl_i(top_lvl),
    .cpu_win_o(cpu_win),
    .dma_win_o(dma_win)
  );

  // Next state.
  logic              cpu_gnt_d;
  logic [NUM_CH-1:0] dma_gnt_d;

  always_comb begin
    cpu_gnt_d = cpu_win;
    dma_gnt_d = '0;
    if (dma_win) dma_gnt_d[pick_idx] = 1'b1;
    ptr_en = dma_win;
    ptr_d  = (pick_idx == LAST) ? '0 : pick_idx + PTR_W'(1);
  end

  // Registers.
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cpu_gnt_o <= 1'b0;
      dma_gnt_o <= '0;
    end else begin
      cpu_gnt_o <= cpu_gnt_d;
      dma_gnt_o <= dma_gnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // Checks on the port-level behaviour.
  assert_one_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({cpu_gnt_o, dma_gnt_o}));

  assert_idle_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!cpu_req_i && (dma_req_i == '0)) |=> (!cpu_gnt_o && (dma_gnt_o == '0)));

  assert_lone_cpu_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cpu_req_i && (dma_req_i == '0)) |=> cpu_gnt_o);

  assert_urgent_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cpu_req_i && (|urg_mask)) |=> (!cpu_gnt_o && (|dma_gnt_o)));

  assert_background_yields_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cpu_req_i && (|back_mask) && !(|urg_mask) && !(|reg_mask)) |=> cpu_gnt_o);

  assert_level_order_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((|urg_mask) && !cpu_req_i) |=> (|(dma_gnt_o & $past(urg_mask))));

  assert_grant_requested_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((dma_gnt_o & ~$past(dma_req_i)) == '0) && (!cpu_gnt_o || $past(cpu_req_i)));

endmodule

// File: tb/dma_cpu_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_cpu_arbiter_tb_top;

  localparam int N = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cpu_req = 1'b0;
  logic [N-1:0]   dma_req = '0;
  logic [2*N-1:0] dma_pri = '0;
  logic           cpu_gnt;
  logic [N-1:0]   dma_gnt;

  always #5 clk = ~clk;

  dma_cpu_arbiter #(.NUM_CH(N)) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .cpu_req_i(cpu_req),
    .dma_req_i(dma_req),
    .dma_pri_i(dma_pri),
    .cpu_gnt_o(cpu_gnt),
    .dma_gnt_o(dma_gnt)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // Reference state.
  int m_ptr = 0;
  bit m_alt = 0;

  function automatic int lvl_of(input logic [2*N-1:0] pri, input int c);
    logic [1:0] f;
    f = pri[2*c +: 2];
    if (f[1]) return 2;
    if (f == 2'b01) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [N:0] got, input logic [N:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got cpu/dma=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic c, input logic [N-1:0] r,
                      input logic [2*N-1:0] p);
    int best, win;
    logic          e_cpu;
    logic [N-1:0]  e_dma;
    @(negedge clk);
    cpu_req = c; dma_req = r; dma_pri = p;
    best = -1; win = -1; e_cpu = 0; e_dma = '0;
    for (int c2 = 0; c2 < N; c2++)
      if (r[c2] && lvl_of(p, c2) > best) best = lvl_of(p, c2);
    if (best >= 0)
      for (int k = 0; k < N; k++) begin
        int ch = (m_ptr + k) % N;
        if (win < 0 && r[ch] && lvl_of(p, ch) == best) win = ch;
      end
    if (win < 0) e_cpu = c;
    else if (!c) e_dma[win] = 1;
    else if (best == 2) e_dma[win] = 1;
    else if (best == 0) e_cpu = 1;
    else begin
      if (m_alt) e_dma[win] = 1; else e_cpu = 1;
      m_alt = !m_alt;
    end
    if (e_dma != '0) m_ptr = (win + 1) % N;
    @(posedge clk);
    #1;
    check(tag, {cpu_gnt, dma_gnt}, {e_cpu, e_dma});
    total++;
    if ($countones({cpu_gnt, dma_gnt}) > 1) begin
      bad++;
      $display("FAIL R2: grant %b has %0d bits expected at most 1",
               {cpu_gnt, dma_gnt}, $countones({cpu_gnt, dma_gnt}));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_req = 0; dma_req = '0; dma_pri = '0;
    #1;
    check("R1 async clear", {cpu_gnt, dma_gnt}, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_ptr = 0; m_alt = 0;
    repeat (3) step("R1 idle after reset", 0, '0, '0);
  endtask

  // Level fields: 00 background, 01 regular, 10/11 urgent.
  function automatic logic [2*N-1:0] all_pri(input logic [1:0] f);
    logic [2*N-1:0] v;
    for (int c = 0; c < N; c++) v[2*c +: 2] = f;
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step("R1 reset state", 0, '0, '0);
    step("R3 no requests", 0, '0, all_pri(2'b10));
    step("R4 lone cpu", 1, '0, '0);
    step("R4 lone channel 3", 0, 5'b01000, all_pri(2'b00));
    step("R6 urgent ch1 vs cpu", 1, 5'b00010, all_pri(2'b10));
    step("R5 code 11 is urgent", 1, 5'b00100, all_pri(2'b11));
    step("R7 background ch4 vs cpu", 1, 5'b10000, all_pri(2'b00));
    step("R5 code 00 is background", 1, 5'b00001, all_pri(2'b00));
    // Regular contests: cpu first after reset, then alternate.
    do_reset();
    step("R1 first regular contest to cpu", 1, 5'b00001, all_pri(2'b01));
    step("R8 second contest to dma", 1, 5'b00001, all_pri(2'b01));
    step("R8 urgent cycle leaves toggle", 1, 5'b00001, all_pri(2'b10));
    step("R8 third contest to cpu", 1, 5'b00001, all_pri(2'b01));
    step("R8 fourth contest to dma", 1, 5'b00010, all_pri(2'b01));
    step("R9 urgent beats regular and background", 0, 5'b01011,
         10'b00_01_00_10_00);
    step("R9 regular beats background", 0, 5'b10001, 10'b00_00_00_00_01);
    do_reset();
    for (int i = 0; i < 12; i++)
      step("R10 rotation among urgent ties", 0, 5'b11111, all_pri(2'b10));
    step("R10 skip non-requesters", 0, 5'b10010, all_pri(2'b01));
    step("R10 pointer held on cpu grant", 1, 5'b00000, '0);
    step("R10 search resumes", 0, 5'b10010, all_pri(2'b01));
    for (int i = 0; i < 3000; i++)
      step("R11 random mix", 1'($urandom), 5'($urandom), 10'($urandom));
    for (int i = 0; i < 1000; i++)
      step("R8 random regular", 1'($urandom), 5'($urandom),
           all_pri({1'b0, 1'($urandom % 4 != 0)}));
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule